// File: doc/BRIEF.md
# DRAM Parallel Test Mode Logic

This block is the device-side control of a small dynamic memory model. It samples the three active-low strobes (row strobe, column strobe, write enable) on a system clock and sorts each row-strobe cycle by edge order. The cycle is an access cycle when the column strobe is high as the row strobe falls. It is a counter refresh when the column strobe is already low. It is a test-entry refresh when write enable is also low, with enough margin on both sides of the row strobe edge. Access cycles latch a row address, and each later column-strobe fall performs one read or write, so several columns can be used under one open row.

While the latched test mode is active, the block treats the cells as groups of eight. The column address bits at positions 0, 1 and 10 pick a cell within a group, and in test mode they have no effect. A write stores the data bit into all eight cells of the group. A read returns one pass/fail bit that is high only when the eight cells agree. Test-mode reads arrive a configurable number of cycles later than normal reads. The storage is a small register array. Column bits 2 and up select the group, through a parameterised number of bits. Higher column bits alias.

Top module: `ptm_test_dram`

## Requirements
- R1: After reset, test_active is 0, dq_oe is 0, dq_out is 0 and refresh_row is 0.
- R2: Outside test mode, a column-strobe fall during an access cycle writes din into the single addressed cell if we_n is low. If we_n is high, it reads that cell. The read data appears with dq_oe high ACC_CYC clock edges after the edge that first samples cas_n low.
- R3: dq_oe is high only while cas_n was low at the latest clock edge, and it drops at the first edge that samples cas_n high. dq_out is 0 whenever dq_oe is 0.
- R4: A refresh cycle enters test mode when three conditions hold. cas_n is low when ras_n is first sampled low. we_n is low on that edge and on the WE_SETUP_CYC edges before it. we_n is still low on the following WE_HOLD_CYC edges. test_active becomes 1 on the last of those hold edges.
- R5: A refresh cycle with too little we_n setup, or with we_n rising before the hold edges complete, does not enter test mode. It acts as a normal counter refresh.
- R6: Once set, test_active stays 1 through any number of access cycles.
- R7: A counter refresh with we_n high clears test_active on the edge where ras_n is first sampled low.
- R8: A row-only refresh clears test_active on the edge that samples ras_n high again. This is an access cycle in which cas_n never falls.
- R9: In test mode, a write stores din into all eight cells that share row and group bits. These cells differ only in column bits 0, 1 and 10.
- R10: In test mode, a read returns 1 when the eight cells of the addressed group are all equal and 0 otherwise. Column bits 0, 1 and 10 do not affect the result.
- R11: In test mode, read data appears ACC_CYC + TEST_DLY_CYC edges after the edge that first samples cas_n low.
- R12: Every refresh with cas_n low at the row-strobe fall increments refresh_row by one, modulo 2^ROW_W. This includes test-entry and failed-entry cycles. A row-only refresh leaves refresh_row unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | 11 | Multiplexed row/column address |
| din | input | 1 | Write data bit |
| dq_out | output | 1 | Read data, 0 when not driven |
| dq_oe | output | 1 | Output enable; low means the data pin floats |
| test_active | output | 1 | Parallel test mode latch |
| refresh_row | output | ROW_W | Internal refresh row counter |

## Verification
A wrong cycle decode appears on test_active within one clock of the row strobe edge that caused it. A missed refresh shows on refresh_row one clock after the row strobe falls. A mode flag that is stale or lost does not show up until the next read, through two symptoms. The first is a wrong dq_oe latency, one cycle early or late. The second is a pass/fail bit where a single cell value was expected, or the reverse. A broken broadcast write stays hidden in test mode when all eight cells already match. It shows as soon as the cells are read back singly after exit, so the checks use mixed groups and cross between the modes.

// File: rtl/ptm_pkg.sv
package ptm_pkg;

    // The group is the eight cells that collapse together in test mode.
    localparam int GRP_BITS   = 3;
    localparam int GRP_CELLS  = 1 << GRP_BITS;
    // Column bit that joins bits 1:0 as the in-group selector.
    localparam int COL_HI_IGN = 10;
    localparam int COL_LO_IGN = 2;
    localparam int ADDR_W     = COL_HI_IGN + 1;

    typedef enum logic [1:0] {
        CYC_IDLE,
        CYC_ACCESS,
        CYC_ENTRY_HOLD,
        CYC_REFRESH
    } cycle_e;

    typedef struct packed {
        logic fire;
        logic write;
        logic test;
    } col_op_t;

    function automatic logic group_uniform(input logic [GRP_CELLS-1:0] g);
        return (&g) | ~(|g);
    endfunction

    function automatic logic [GRP_BITS-1:0] grp_sel(input logic hi, input logic [1:0] lo);
        return {hi, lo};
    endfunction

endpackage

// File: rtl/ptm_strobe_fsm.sv
module ptm_strobe_fsm
    import ptm_pkg::*;
#(
    parameter int ROW_W        = 2,
    parameter int WE_SETUP_CYC = 1,
    parameter int WE_HOLD_CYC  = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ras_n,
    input  logic             cas_n,
    input  logic             we_n,
    input  logic [ROW_W-1:0] row_addr,
    output logic             test_active,
    output logic [ROW_W-1:0] refresh_row,
    output logic [ROW_W-1:0] row_q,
    output col_op_t          col_op
);
    localparam int CNT_MAX = (WE_SETUP_CYC > WE_HOLD_CYC) ? WE_SETUP_CYC : WE_HOLD_CYC;
    localparam int CW      = $clog2(CNT_MAX + 2);
    localparam logic [CW-1:0] SETUP_REQ = CW'(WE_SETUP_CYC);
    localparam logic [CW-1:0] HOLD_LAST = CW'(WE_HOLD_CYC - 1);

    logic          ras_q;
    logic          cas_q;
    cycle_e        cyc;
    logic [CW-1:0] we_run;
    logic [CW-1:0] hold_cnt;
    logic          cas_seen;
    logic          ras_fall;
    logic          cas_fall;

    assign ras_fall = ras_q & ~ras_n;
    assign cas_fall = cas_q & ~cas_n;

    always_comb begin
        col_op.fire  = (cyc == CYC_ACCESS) && !ras_n && cas_fall;
        col_op.write = !we_n;
        col_op.test  = test_active;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ras_q       <= 1'b1;
            cas_q       <= 1'b1;
            cyc         <= CYC_IDLE;
            we_run      <= '0;
            hold_cnt    <= '0;
            cas_seen    <= 1'b0;
            test_active <= 1'b0;
            refresh_row <= '0;
            row_q       <= '0;
        end else begin
            ras_q <= ras_n;
            cas_q <= cas_n;
            if (we_n)
                we_run <= '0;
            else if (we_run != SETUP_REQ)
                we_run <= we_run + CW'(1);

            case (cyc)
                CYC_IDLE: begin
                    if (ras_fall) begin
                        if (!cas_n) begin
                            refresh_row <= refresh_row + ROW_W'(1);
                            if (!we_n && (we_run >= SETUP_REQ)) begin
                                hold_cnt <= '0;
                                cyc      <= CYC_ENTRY_HOLD;
                            end else begin
                                test_active <= 1'b0;
                                cyc         <= CYC_REFRESH;
                            end
                        end else begin
                            row_q    <= row_addr;
                            cas_seen <= 1'b0;
                            cyc      <= CYC_ACCESS;
                        end
                    end
                end
                CYC_ACCESS: begin
                    if (ras_n) begin
                        if (!cas_seen)
                            test_active <= 1'b0;
                        cyc <= CYC_IDLE;
                    end else if (cas_fall) begin
                        cas_seen <= 1'b1;
                    end
                end
                CYC_ENTRY_HOLD: begin
                    if (ras_n) begin
                        test_active <= 1'b0;
                        cyc         <= CYC_IDLE;
                    end else if (we_n) begin
                        test_active <= 1'b0;
                        cyc         <= CYC_REFRESH;
                    end else if (hold_cnt == HOLD_LAST) begin
                        test_active <= 1'b1;
                        cyc         <= CYC_REFRESH;
                    end else begin
                        hold_cnt <= hold_cnt + CW'(1);
                    end
                end
                CYC_REFRESH: begin
                    if (ras_n)
                        cyc <= CYC_IDLE;
                end
                default: cyc <= CYC_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/ptm_cell_array.sv
module ptm_cell_array
    import ptm_pkg::*;
#(
    parameter int ROW_W = 2,
    parameter int MID_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ROW_W-1:0]  row,
    input  logic [ADDR_W-1:0] col,
    input  logic              wr_en,
    input  logic              tm,
    input  logic              din,
    output logic              rd_bit,
    output logic              rd_uniform
);
    localparam int BASE_W = ROW_W + MID_W;
    localparam int IDX_W  = BASE_W + GRP_BITS;
    localparam int DEPTH  = 1 << IDX_W;

    logic [DEPTH-1:0]     cells;
    logic [BASE_W-1:0]    base;
    logic [GRP_BITS-1:0]  sel;
    logic [IDX_W-1:0]     idx;
    logic [IDX_W-1:0]     grp_lo;
    logic [GRP_CELLS-1:0] grp;

    assign base   = {row, col[COL_LO_IGN +: MID_W]};
    assign sel    = grp_sel(col[COL_HI_IGN], col[1:0]);
    assign idx    = {base, sel};
    assign grp_lo = {base, {GRP_BITS{1'b0}}};
    assign grp    = cells[grp_lo +: GRP_CELLS];

    generate
        if (COL_LO_IGN + MID_W < COL_HI_IGN) begin : g_alias
            logic unused_col_alias;
            assign unused_col_alias = ^col[COL_HI_IGN-1:COL_LO_IGN+MID_W];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            cells <= '0;
        end else if (wr_en) begin
            if (tm)
                cells[grp_lo +: GRP_CELLS] <= {GRP_CELLS{din}};
            else
                cells[idx] <= din;
        end
    end

    assign rd_bit     = cells[idx];
    assign rd_uniform = group_uniform(grp);

endmodule

// File: rtl/ptm_read_path.sv
module ptm_read_path #(
    parameter int ACC_CYC      = 2,
    parameter int TEST_DLY_CYC = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic cas_n,
    input  logic start,
    input  logic tm,
    input  logic bit_norm,
    input  logic bit_cmp,
    output logic dq_out,
    output logic dq_oe
);
    localparam int LAT_N = ACC_CYC;
    localparam int LAT_T = ACC_CYC + TEST_DLY_CYC;
    localparam int LW    = $clog2(LAT_T + 1);
    localparam logic [LW-1:0] LOAD_N = LW'(LAT_N - 1);
    localparam logic [LW-1:0] LOAD_T = LW'(LAT_T - 1);

    logic          pend;
    logic [LW-1:0] cnt;
    logic          dq_q;
    logic          oe_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= 1'b0;
            cnt  <= '0;
            dq_q <= 1'b0;
            oe_q <= 1'b0;
        end else if (cas_n) begin
            pend <= 1'b0;
            oe_q <= 1'b0;
        end else if (start) begin
            pend <= 1'b1;
            oe_q <= 1'b0;
            cnt  <= tm ? LOAD_T : LOAD_N;
            dq_q <= tm ? bit_cmp : bit_norm;
        end else if (pend) begin
            if (cnt == '0) begin
                oe_q <= 1'b1;
                pend <= 1'b0;
            end else begin
                cnt <= cnt - LW'(1);
            end
        end
    end

    assign dq_oe  = oe_q;
    assign dq_out = oe_q & dq_q;

endmodule

// File: rtl/ptm_test_dram.sv
module ptm_test_dram
    import ptm_pkg::*;
#(
    parameter int ROW_W        = 2,
    parameter int MID_W        = 2,
    parameter int ACC_CYC      = 2,
    parameter int TEST_DLY_CYC = 1,
    parameter int WE_SETUP_CYC = 1,
    parameter int WE_HOLD_CYC  = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              din,
    output logic              dq_out,
    output logic              dq_oe,
    output logic              test_active,
    output logic [ROW_W-1:0]  refresh_row
);
    col_op_t          op;
    logic [ROW_W-1:0] row_q;
    logic             wr_en;
    logic             rd_start;
    logic             bit_norm;
    logic             bit_cmp;

    assign wr_en    = op.fire & op.write;
    assign rd_start = op.fire & ~op.write;

    ptm_strobe_fsm #(
        .ROW_W        (ROW_W),
        .WE_SETUP_CYC (WE_SETUP_CYC),
        .WE_HOLD_CYC  (WE_HOLD_CYC)
    ) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .ras_n       (ras_n),
        .cas_n       (cas_n),
        .we_n        (we_n),
        .row_addr    (addr[ROW_W-1:0]),
        .test_active (test_active),
        .refresh_row (refresh_row),
        .row_q       (row_q),
        .col_op      (op)
    );

    ptm_cell_array #(
        .ROW_W (ROW_W),
        .MID_W (MID_W)
    ) u_array (
        .clk        (clk),
        .rst        (rst),
        .row        (row_q),
        .col        (addr),
        .wr_en      (wr_en),
        .tm         (op.test),
        .din        (din),
        .rd_bit     (bit_norm),
        .rd_uniform (bit_cmp)
    );

    ptm_read_path #(
        .ACC_CYC      (ACC_CYC),
        .TEST_DLY_CYC (TEST_DLY_CYC)
    ) u_read (
        .clk      (clk),
        .rst      (rst),
        .cas_n    (cas_n),
        .start    (rd_start),
        .tm       (op.test),
        .bit_norm (bit_norm),
        .bit_cmp  (bit_cmp),
        .dq_out   (dq_out),
        .dq_oe    (dq_oe)
    );

endmodule

// File: rtl/ptm_test_dram_chk.sv
module ptm_test_dram_chk #(
    parameter int ROW_W = 2
) (
    input logic             clk,
    input logic             rst,
    input logic             ras_n,
    input logic             cas_n,
    input logic             we_n,
    input logic             dq_oe,
    input logic             test_active,
    input logic [ROW_W-1:0] refresh_row
);

    // R3: output enable only follows a sampled-low column strobe
    a_r3_oe_needs_cas: assert property (@(posedge clk) disable iff (rst)
        dq_oe |-> !$past(cas_n));

    // R4: the mode latch sets only on an edge with WE and RAS low
    a_r4_entry_strobes: assert property (@(posedge clk) disable iff (rst)
        $rose(test_active) |-> (!$past(we_n) && !$past(ras_n)));

    // R7 and R8: the latch clears on a CBR edge or a row-strobe rise
    a_r7_exit_cycle: assert property (@(posedge clk) disable iff (rst)
        $fell(test_active) |-> ($past(ras_n) || !$past(cas_n)));

    // R6: no mode change while the row strobe rests high
    a_r6_latched_idle: assert property (@(posedge clk) disable iff (rst)
        ($past(ras_n) && $past(ras_n, 2)) |-> $stable(test_active));

    // R12: the counter only steps by one
    a_r12_refresh_step: assert property (@(posedge clk) disable iff (rst)
        (refresh_row != $past(refresh_row)) |-> (refresh_row == $past(refresh_row) + ROW_W'(1)));

    // R12: the counter only moves on a CAS-before-RAS edge
    a_r12_refresh_cause: assert property (@(posedge clk) disable iff (rst)
        (refresh_row != $past(refresh_row)) |-> (!$past(ras_n) && !$past(cas_n)));

endmodule

bind ptm_test_dram ptm_test_dram_chk #(.ROW_W(ROW_W)) u_chk (.*);

// File: tb/ptm_test_dram_tb.sv
module ptm_test_dram_tb;
    localparam int ROW_W   = 2;
    localparam int LAT_N   = 2;
    localparam int LAT_T   = 3;
    localparam int WD_CYC  = 20000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ras_n = 1'b1;
    logic        cas_n = 1'b1;
    logic        we_n = 1'b1;
    logic [10:0] addr = '0;
    logic        din = 1'b0;
    logic        dq_out;
    logic        dq_oe;
    logic        test_active;
    logic [ROW_W-1:0] refresh_row;

    int  checks = 0;
    int  errors = 0;
    int  cyc = 0;
    bit  done = 1'b0;
    bit  tm_exp = 1'b0;
    bit  oe_prev = 1'b0;

    typedef struct {
        bit    exp;
        int    due;
        string tag;
    } item_t;
    item_t sb[$];

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    ptm_test_dram u_dut (
        .clk(clk), .rst(rst), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .addr(addr), .din(din), .dq_out(dq_out), .dq_oe(dq_oe),
        .test_active(test_active), .refresh_row(refresh_row)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [10:0] col_of(input int mid, input int g);
        return 11'((((g >> 2) & 1) << 10) | (mid << 2) | (g & 3));
    endfunction

    // monitor: pops one expected item per rising output enable
    always @(negedge clk) begin
        if (!rst && dq_oe && !oe_prev) begin
            if (sb.size() == 0) begin
                check(1'b0, "R3 unexpected drive", 1, 0);
            end else begin
                item_t it;
                it = sb.pop_front();
                check(dq_out == it.exp, it.tag, int'(dq_out), int'(it.exp));
                check(cyc == it.due, {it.tag, " latency"}, cyc, it.due);
            end
        end
        oe_prev = dq_oe;
    end

    task automatic row_open(input int row);
        addr = 11'(row); ras_n = 1'b0; tick(1);
    endtask

    task automatic row_close();
        ras_n = 1'b1; addr = '0; tick(2);
    endtask

    task automatic col_write(input logic [10:0] c, input bit d);
        addr = c; din = d; we_n = 1'b0; cas_n = 1'b0; tick(1);
        cas_n = 1'b1; we_n = 1'b1; tick(1);
    endtask

    task automatic col_read(input logic [10:0] c, input bit exp, input string tag);
        item_t it;
        int lat;
        lat = tm_exp ? LAT_T : LAT_N;
        it.exp = exp; it.due = cyc + 1 + lat; it.tag = tag;
        sb.push_back(it);
        addr = c; we_n = 1'b1; cas_n = 1'b0; tick(lat + 1);
        cas_n = 1'b1; tick(1);
        check(dq_oe == 1'b0, "R3 oe after cas high", int'(dq_oe), 0);
        check(dq_out == 1'b0, "R3 dq idle value", int'(dq_out), 0);
    endtask

    task automatic cbr_refresh();
        cas_n = 1'b0; tick(1); ras_n = 1'b0; tick(2);
        ras_n = 1'b1; cas_n = 1'b1; tick(2);
    endtask

    task automatic ras_only(input int row);
        addr = 11'(row); ras_n = 1'b0; tick(2); ras_n = 1'b1; tick(2);
    endtask

    task automatic wcbr_good();
        we_n = 1'b0; cas_n = 1'b0; tick(1); ras_n = 1'b0; tick(2);
        ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1; tick(2);
    endtask

    task automatic wcbr_short_setup();
        we_n = 1'b0; cas_n = 1'b0; ras_n = 1'b0; tick(2);
        ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1; tick(2);
    endtask

    task automatic wcbr_early_release();
        we_n = 1'b0; cas_n = 1'b0; tick(1); ras_n = 1'b0; tick(1);
        we_n = 1'b1; tick(1); ras_n = 1'b1; cas_n = 1'b1; tick(2);
    endtask

    initial begin
        tick(4);
        rst = 1'b0;
        tick(1);
        check(test_active == 1'b0, "R1 test_active", int'(test_active), 0);
        check(dq_oe == 1'b0, "R1 dq_oe", int'(dq_oe), 0);
        check(dq_out == 1'b0, "R1 dq_out", int'(dq_out), 0);
        check(refresh_row == 0, "R1 refresh_row", int'(refresh_row), 0);

        // R2: normal writes and reads, several columns under one row
        row_open(1);
        for (int g = 0; g < 8; g++) col_write(col_of(1, g), 1'b1);
        col_write(col_of(2, 3), 1'b0);
        col_write(col_of(3, 2), 1'b1);
        col_read(col_of(1, 7), 1'b1, "R2 row1 grp1 cell7");
        col_read(col_of(3, 2), 1'b1, "R2 row1 grp3 cell2");
        col_read(col_of(3, 3), 1'b0, "R2 row1 grp3 cell3");
        col_read(col_of(2, 0), 1'b0, "R2 row1 grp2 cell0");
        row_close();
        row_open(2);
        col_write(col_of(1, 0), 1'b1);
        col_read(col_of(1, 1), 1'b0, "R2 row2 grp1 cell1");
        col_read(col_of(1, 0), 1'b1, "R2 row2 grp1 cell0");
        row_close();
        check(test_active == 1'b0, "R8 access with cas keeps mode", int'(test_active), 0);

        // R12: counter refresh and row-only refresh
        cbr_refresh();
        check(refresh_row == 1, "R12 cbr step", int'(refresh_row), 1);
        ras_only(3);
        check(refresh_row == 1, "R12 row-only no step", int'(refresh_row), 1);

        // R5: failed entries act as plain refreshes
        wcbr_short_setup();
        check(test_active == 1'b0, "R5 short setup", int'(test_active), 0);
        check(refresh_row == 2, "R12 failed entry step", int'(refresh_row), 2);
        wcbr_early_release();
        check(test_active == 1'b0, "R5 early release", int'(test_active), 0);
        check(refresh_row == 3, "R12 early release step", int'(refresh_row), 3);

        // R4: proper entry, counter wraps
        wcbr_good();
        tm_exp = 1'b1;
        check(test_active == 1'b1, "R4 entry", int'(test_active), 1);
        check(refresh_row == 0, "R12 wrap", int'(refresh_row), 0);

        // R10 and R11: compressed reads, ignored bits
        row_open(1);
        col_read(col_of(1, 0), 1'b1, "R10 uniform ones");
        col_read(col_of(1, 6), 1'b1, "R10 ignored bits ones");
        col_read(col_of(2, 5), 1'b1, "R10 uniform zeros");
        col_read(col_of(3, 0), 1'b0, "R10 mixed group");
        col_read(col_of(3, 5), 1'b0, "R10 mixed group alt sel");
        row_close();
        check(test_active == 1'b1, "R6 latched after access", int'(test_active), 1);

        // R9: broadcast writes
        row_open(1);
        col_write(col_of(3, 5), 1'b0);
        col_read(col_of(3, 1), 1'b1, "R9 broadcast zero");
        col_write(col_of(2, 7), 1'b1);
        row_close();
        row_open(2);
        col_read(col_of(1, 4), 1'b0, "R10 row2 mixed");
        row_close();
        check(test_active == 1'b1, "R6 latched after second access", int'(test_active), 1);

        // R7: exit by counter refresh
        cbr_refresh();
        tm_exp = 1'b0;
        check(test_active == 1'b0, "R7 exit", int'(test_active), 0);
        check(refresh_row == 1, "R12 exit step", int'(refresh_row), 1);
        row_open(1);
        col_read(col_of(3, 2), 1'b0, "R9 cleared cell");
        col_read(col_of(2, 4), 1'b1, "R9 set cell");
        col_read(col_of(2, 0), 1'b1, "R9 set cell sel0");
        row_close();

        // R8: exit by row-only refresh
        wcbr_good();
        check(test_active == 1'b1, "R4 re-entry", int'(test_active), 1);
        check(refresh_row == 2, "R12 re-entry step", int'(refresh_row), 2);
        ras_only(0);
        check(test_active == 1'b0, "R8 exit", int'(test_active), 0);
        check(refresh_row == 2, "R12 row-only after exit", int'(refresh_row), 2);

        tick(4);
        check(sb.size() == 0, "R2 pending reads", sb.size(), 0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (WD_CYC) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R2 watchdog actual=%0d expected=%0d", WD_CYC, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule